// File: doc/BRIEF.md
# DMA Channel Start Control Sequencer

This block is the control and status front end of one descriptor-chain DMA channel. Software programs it through a small register port. It holds a control word with enable, mode and interrupt-enable bits. It holds the address of the first chain descriptor, written as a low word and a high word. It also exposes a status word that shows whether the channel is busy. A separate command word carries start, suspend, resume and stop requests as write pulses.

A start command is taken only when the channel is enabled, set to normal mode and not busy. Once taken, the sequencer asks a descriptor engine to fetch the first descriptor at the programmed address. When the engine acknowledges, the channel runs the transfer. It can be suspended, resumed or stopped. When the engine reports the end of the chain, the channel goes idle and sets a done flag, and it raises an interrupt if that is enabled. The interrupt is cleared by writing 1 to the done flag. The memory interface and the data mover sit outside the block.

Top module: `dma_chan_start_ctl`

## Requirements
- R1: After reset, fetch_req, chan_run and irq are 0, and reads of the control (offset 0), status (offset 2), descriptor-low (offset 3) and descriptor-high (offset 4) registers all return 0. A read returns the value at rd_addr on the clock edge that follows.
- R2: Control register at offset 0: bit0 enables the channel, bit1 selects the alternate (non-normal) mode when 1, and bit2 enables the interrupt. These three bits read back as written, and all other bits read 0.
- R3: While the channel is inactive, offset 3 stores the low DATA_W bits of the descriptor address. Offset 4 stores the upper DESC_AW-DATA_W bits; write bits above that width are dropped and read back as 0.
- R4: Writing bit0 of the command register (offset 1) starts the channel if it is enabled, in normal mode and inactive. On the next cycle fetch_req is 1, fetch_addr equals {high, low}, and status bit0 (active) is 1.
- R5: A start command is ignored if the channel is disabled, in alternate mode, or already active. fetch_req and the status word do not change.
- R6: fetch_ack while fetch_req is 1 makes chan_run 1 and fetch_req 0 on the next cycle.
- R7: Command bit1 (suspend) while running makes chan_run 0 and sets status bit3 (suspended), and active stays 1. Command bit2 (resume) returns the channel to running. chain_end is ignored while suspended.
- R8: Command bit3 (stop) while fetching, running or suspended makes active, fetch_req and chan_run 0 on the next cycle and leaves the done bit unchanged. Stop takes priority over chain_end in the same cycle.
- R9: chain_end while running clears active and sets status bit1 (done) on the next cycle. irq rises on that same cycle if the interrupt is enabled, and stays 0 if it is not.
- R10: Writing 1 to status bit1 clears done and irq on the next cycle. Writing 0 there leaves them unchanged.
- R11: Writes to offsets 3 and 4 while active are ignored and set status bit2 (error). The error bit is cleared by writing 1 to status bit2.
- R12: After a chain completes, a new start is accepted and fetches from the descriptor address currently programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | REG_AW | Register write offset |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | REG_AW | Register read offset |
| rd_data | output | DATA_W | Registered read data |
| fetch_req | output | 1 | Request to fetch the first descriptor |
| fetch_addr | output | DESC_AW | Address of the first descriptor |
| fetch_ack | input | 1 | Descriptor engine accepted the fetch |
| chain_end | input | 1 | Descriptor engine reports end of chain |
| chan_run | output | 1 | Channel is running its transfer |
| irq | output | 1 | Channel interrupt (done and enabled) |

## Verification
The bench builds the block with DATA_W=32, DESC_AW=40 and REG_AW=3. The high descriptor word is therefore only 8 bits wide, so dropping the excess write bits and joining the two halves into fetch_addr can both be seen. A 40-bit address also shows whether the high half lands at the right bit position of the fetch address.

// File: rtl/dmastart_pkg.sv
package dmastart_pkg;
  localparam int OFF_CTRL   = 0;
  localparam int OFF_CMD    = 1;
  localparam int OFF_STATUS = 2;
  localparam int OFF_NDLO   = 3;
  localparam int OFF_NDHI   = 4;

  localparam int CTRL_EN    = 0;
  localparam int CTRL_ALT   = 1;
  localparam int CTRL_IRQEN = 2;

  localparam int CMD_START  = 0;
  localparam int CMD_SUSP   = 1;
  localparam int CMD_RESUME = 2;
  localparam int CMD_STOP   = 3;

  localparam int ST_ACT_B   = 0;
  localparam int ST_DONE_B  = 1;
  localparam int ST_ERR_B   = 2;
  localparam int ST_SUSP_B  = 3;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_FETCH  = 3'd1,
    S_ACTIVE = 3'd2,
    S_SUSP   = 3'd3,
    S_DONE   = 3'd4
  } chan_state_e;
endpackage

// File: rtl/dmastart_regs.sv
module dmastart_regs
  import dmastart_pkg::*;
#(
  parameter int REG_AW  = 3,
  parameter int DATA_W  = 32,
  parameter int DESC_AW = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [REG_AW-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [REG_AW-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               active,
  input  logic               suspended,
  input  logic               done,
  output logic               ctrl_en,
  output logic               ctrl_alt,
  output logic               ctrl_irq_en,
  output logic               err_q,
  output logic               cmd_start,
  output logic               cmd_susp,
  output logic               cmd_resume,
  output logic               cmd_stop,
  output logic               done_clr,
  output logic [DESC_AW-1:0] desc_addr
);
  localparam int HI_W = DESC_AW - DATA_W;

  logic [DATA_W-1:0] nd_lo;
  logic [HI_W-1:0]   nd_hi;
  logic              sel_ctrl, sel_cmd, sel_stat, sel_lo, sel_hi;
  logic              nd_touch;
  logic [DATA_W-1:0] stat_word;

  assign sel_ctrl = wr_en && (wr_addr == REG_AW'(OFF_CTRL));
  assign sel_cmd  = wr_en && (wr_addr == REG_AW'(OFF_CMD));
  assign sel_stat = wr_en && (wr_addr == REG_AW'(OFF_STATUS));
  assign sel_lo   = wr_en && (wr_addr == REG_AW'(OFF_NDLO));
  assign sel_hi   = wr_en && (wr_addr == REG_AW'(OFF_NDHI));
  assign nd_touch = sel_lo || sel_hi;

  assign cmd_start  = sel_cmd && wr_data[CMD_START];
  assign cmd_susp   = sel_cmd && wr_data[CMD_SUSP];
  assign cmd_resume = sel_cmd && wr_data[CMD_RESUME];
  assign cmd_stop   = sel_cmd && wr_data[CMD_STOP];
  assign done_clr   = sel_stat && wr_data[ST_DONE_B];

  assign desc_addr = {nd_hi, nd_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en     <= 1'b0;
      ctrl_alt    <= 1'b0;
      ctrl_irq_en <= 1'b0;
      nd_lo       <= '0;
      nd_hi       <= '0;
      err_q       <= 1'b0;
    end else begin
      if (sel_ctrl) begin
        ctrl_en     <= wr_data[CTRL_EN];
        ctrl_alt    <= wr_data[CTRL_ALT];
        ctrl_irq_en <= wr_data[CTRL_IRQEN];
      end
      if (sel_lo && !active) nd_lo <= wr_data;
      if (sel_hi && !active) nd_hi <= wr_data[HI_W-1:0];
      if (nd_touch && active)
        err_q <= 1'b1;
      else if (sel_stat && wr_data[ST_ERR_B])
        err_q <= 1'b0;
    end
  end

  always_comb begin
    stat_word            = '0;
    stat_word[ST_ACT_B]  = active;
    stat_word[ST_DONE_B] = done;
    stat_word[ST_ERR_B]  = err_q;
    stat_word[ST_SUSP_B] = suspended;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      case (rd_addr)
        REG_AW'(OFF_CTRL): begin
          rd_data[CTRL_EN]    <= ctrl_en;
          rd_data[CTRL_ALT]   <= ctrl_alt;
          rd_data[CTRL_IRQEN] <= ctrl_irq_en;
        end
        REG_AW'(OFF_STATUS): rd_data <= stat_word;
        REG_AW'(OFF_NDLO):   rd_data <= nd_lo;
        REG_AW'(OFF_NDHI):   rd_data <= DATA_W'(nd_hi);
        default:             rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dmastart_fsm.sv
module dmastart_fsm
  import dmastart_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ctrl_en,
  input  logic ctrl_alt,
  input  logic cmd_start,
  input  logic cmd_susp,
  input  logic cmd_resume,
  input  logic cmd_stop,
  input  logic fetch_ack,
  input  logic chain_end,
  output logic fetch_req,
  output logic chan_run,
  output logic active,
  output logic suspended,
  output logic done_set
);
  chan_state_e state_q, state_n;
  logic        start_ok;

  assign active    = (state_q == S_FETCH) || (state_q == S_ACTIVE) || (state_q == S_SUSP);
  assign start_ok  = cmd_start && ctrl_en && !ctrl_alt && !active;
  assign fetch_req = (state_q == S_FETCH);
  assign chan_run  = (state_q == S_ACTIVE);
  assign suspended = (state_q == S_SUSP);
  assign done_set  = (state_q == S_ACTIVE) && chain_end && !cmd_stop;

  always_comb begin
    state_n = state_q;
    case (state_q)
      S_IDLE:   if (start_ok) state_n = S_FETCH;
      S_FETCH: begin
        if (cmd_stop)       state_n = S_IDLE;
        else if (fetch_ack) state_n = S_ACTIVE;
      end
      S_ACTIVE: begin
        if (cmd_stop)       state_n = S_IDLE;
        else if (chain_end) state_n = S_DONE;
        else if (cmd_susp)  state_n = S_SUSP;
      end
      S_SUSP: begin
        if (cmd_stop)        state_n = S_IDLE;
        else if (cmd_resume) state_n = S_ACTIVE;
      end
      S_DONE:   state_n = start_ok ? S_FETCH : S_IDLE;
      default:  state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_IDLE;
    else     state_q <= state_n;
  end
endmodule

// File: rtl/dmastart_irq.sv
module dmastart_irq (
  input  logic clk,
  input  logic rst,
  input  logic done_set,
  input  logic done_clr,
  input  logic irq_en,
  output logic done_q,
  output logic irq_q
);
  logic done_n;

  assign done_n = done_set || (done_q && !done_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= done_n;
      irq_q  <= done_n && irq_en;
    end
  end
endmodule

// File: rtl/dma_chan_start_ctl.sv
module dma_chan_start_ctl #(
  parameter int REG_AW  = 3,
  parameter int DATA_W  = 32,
  parameter int DESC_AW = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [REG_AW-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [REG_AW-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               fetch_req,
  output logic [DESC_AW-1:0] fetch_addr,
  input  logic               fetch_ack,
  input  logic               chain_end,
  output logic               chan_run,
  output logic               irq
);
  logic ctrl_en, ctrl_alt, ctrl_irq_en, err_q;
  logic cmd_start, cmd_susp, cmd_resume, cmd_stop, done_clr;
  logic active, suspended, done_set, done_q;

  dmastart_regs #(.REG_AW(REG_AW), .DATA_W(DATA_W), .DESC_AW(DESC_AW)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .active(active), .suspended(suspended), .done(done_q),
    .ctrl_en(ctrl_en), .ctrl_alt(ctrl_alt), .ctrl_irq_en(ctrl_irq_en), .err_q(err_q),
    .cmd_start(cmd_start), .cmd_susp(cmd_susp), .cmd_resume(cmd_resume), .cmd_stop(cmd_stop),
    .done_clr(done_clr), .desc_addr(fetch_addr)
  );

  dmastart_fsm u_fsm (
    .clk(clk), .rst(rst),
    .ctrl_en(ctrl_en), .ctrl_alt(ctrl_alt),
    .cmd_start(cmd_start), .cmd_susp(cmd_susp), .cmd_resume(cmd_resume), .cmd_stop(cmd_stop),
    .fetch_ack(fetch_ack), .chain_end(chain_end),
    .fetch_req(fetch_req), .chan_run(chan_run), .active(active),
    .suspended(suspended), .done_set(done_set)
  );

  dmastart_irq u_irq (
    .clk(clk), .rst(rst),
    .done_set(done_set), .done_clr(done_clr), .irq_en(ctrl_irq_en),
    .done_q(done_q), .irq_q(irq)
  );
endmodule

// File: rtl/dmastart_chk.sv
module dmastart_chk #(
  parameter int REG_AW  = 3,
  parameter int DATA_W  = 32,
  parameter int DESC_AW = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [REG_AW-1:0]  wr_addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic               fetch_req,
  input logic [DESC_AW-1:0] fetch_addr,
  input logic               fetch_ack,
  input logic               chain_end,
  input logic               chan_run,
  input logic               irq,
  input logic               ctrl_en,
  input logic               ctrl_alt,
  input logic               ctrl_irq_en,
  input logic               active,
  input logic               done_q,
  input logic               err_q
);
  logic is_cmd, is_nd, stop_w, start_w;
  assign is_cmd  = wr_en && (wr_addr == REG_AW'(1));
  assign is_nd   = wr_en && ((wr_addr == REG_AW'(3)) || (wr_addr == REG_AW'(4)));
  assign stop_w  = is_cmd && wr_data[3];
  assign start_w = is_cmd && wr_data[0];

  a_r4_start_fetch: assert property (@(posedge clk) disable iff (rst)
    (start_w && ctrl_en && !ctrl_alt && !active) |=> fetch_req);

  a_r5_start_blocked: assert property (@(posedge clk) disable iff (rst)
    (start_w && !active && (!ctrl_en || ctrl_alt)) |=> !fetch_req);

  a_r6_ack_run: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && fetch_ack && !stop_w) |=> (chan_run && !fetch_req));

  a_r8_stop_clears: assert property (@(posedge clk) disable iff (rst)
    (stop_w && active) |=> (!active && !fetch_req && !chan_run));

  a_r9_end_done: assert property (@(posedge clk) disable iff (rst)
    (chan_run && chain_end && !stop_w) |=> (done_q && !active && (irq == $past(ctrl_irq_en))));

  a_r11_nd_locked: assert property (@(posedge clk) disable iff (rst)
    active |=> (!active || $stable(fetch_addr)));

  a_r11_err_flag: assert property (@(posedge clk) disable iff (rst)
    (is_nd && active) |=> err_q);

  a_r1_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fetch_req, chan_run}));
endmodule

bind dma_chan_start_ctl dmastart_chk #(.REG_AW(REG_AW), .DATA_W(DATA_W), .DESC_AW(DESC_AW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
  .chain_end(chain_end), .chan_run(chan_run), .irq(irq),
  .ctrl_en(ctrl_en), .ctrl_alt(ctrl_alt), .ctrl_irq_en(ctrl_irq_en),
  .active(active), .done_q(done_q), .err_q(err_q)
);

// File: tb/test_dma_chan_start_ctl.sv
`timescale 1ns/1ps
module test_dma_chan_start_ctl;
  localparam int REG_AW  = 3;
  localparam int DATA_W  = 32;
  localparam int DESC_AW = 40;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               wr_en = 1'b0;
  logic [REG_AW-1:0]  wr_addr = '0;
  logic [DATA_W-1:0]  wr_data = '0;
  logic [REG_AW-1:0]  rd_addr = '0;
  logic [DATA_W-1:0]  rd_data;
  logic               fetch_req;
  logic [DESC_AW-1:0] fetch_addr;
  logic               fetch_ack = 1'b0;
  logic               chain_end = 1'b0;
  logic               chan_run;
  logic               irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];

  always #2.5 clk = ~clk;

  dma_chan_start_ctl #(.REG_AW(REG_AW), .DATA_W(DATA_W), .DESC_AW(DESC_AW)) i_dma_chan_start_ctl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_ack(fetch_ack), .chain_end(chain_end), .chan_run(chan_run), .irq(irq)
  );

  // monitor: compares each registered read against the scoreboard queue
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [DATA_W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        failures++;
        $display("FAIL %s rd_data actual=%h expected=%h", t, rd_data, e);
      end
    end
  end

  task automatic expect_rd(input int a, input logic [DATA_W-1:0] e, input string t);
    @(negedge clk);
    rd_addr = REG_AW'(a);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = REG_AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_with_end(input int a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = REG_AW'(a); wr_data = d; chain_end = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; chain_end = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); fetch_ack = 1'b1;
    @(negedge clk); fetch_ack = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk); chain_end = 1'b1;
    @(negedge clk); chain_end = 1'b0;
  endtask

  task automatic chk(input logic [63:0] act, input logic [63:0] e, input string t);
    checks++;
    if (act !== e) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", t, act, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(64'(fetch_req), 0, "R1 fetch_req");
    chk(64'(chan_run), 0, "R1 chan_run");
    chk(64'(irq), 0, "R1 irq");
    expect_rd(0, 32'h0, "R1 ctrl");
    expect_rd(2, 32'h0, "R1 status");
    expect_rd(3, 32'h0, "R1 ndlo");
    expect_rd(4, 32'h0, "R1 ndhi");
    // R3 descriptor halves
    wr(3, 32'h1234_5678);
    wr(4, 32'hFFFF_FFAB);
    expect_rd(3, 32'h1234_5678, "R3 ndlo");
    expect_rd(4, 32'h0000_00AB, "R3 ndhi masked");
    // R2 control readback
    wr(0, 32'hFFFF_FFF6);
    expect_rd(0, 32'h6, "R2 ctrl");
    // R5 disabled / alternate mode
    wr(1, 32'h1);
    chk(64'(fetch_req), 0, "R5 start while disabled");
    expect_rd(2, 32'h0, "R5 status disabled");
    wr(0, 32'h3);
    wr(1, 32'h1);
    chk(64'(fetch_req), 0, "R5 start in alt mode");
    expect_rd(2, 32'h0, "R5 status alt");
    // R4 accepted start
    wr(0, 32'h5);
    wr(1, 32'h1);
    chk(64'(fetch_req), 1, "R4 fetch_req");
    chk(64'(fetch_addr), 64'h00AB_1234_5678, "R4 fetch_addr");
    expect_rd(2, 32'h1, "R4 status active");
    // R11 locked descriptor registers
    wr(3, 32'hDEAD_BEEF);
    expect_rd(3, 32'h1234_5678, "R11 ndlo unchanged");
    expect_rd(2, 32'h5, "R11 error set");
    // R5 start while active
    wr(1, 32'h1);
    chk(64'(fetch_req), 1, "R5 start while active");
    chk(64'(fetch_addr), 64'h00AB_1234_5678, "R5 addr kept");
    // R6 acknowledge
    pulse_ack();
    chk(64'(chan_run), 1, "R6 chan_run");
    chk(64'(fetch_req), 0, "R6 fetch_req");
    // R7 suspend / resume
    wr(1, 32'h2);
    chk(64'(chan_run), 0, "R7 suspended run");
    expect_rd(2, 32'hD, "R7 status suspended");
    pulse_end();
    expect_rd(2, 32'hD, "R7 chain_end ignored");
    chk(64'(irq), 0, "R7 irq");
    wr(1, 32'h4);
    chk(64'(chan_run), 1, "R7 resumed");
    // R8 stop wins over chain_end
    wr_with_end(1, 32'h8);
    chk(64'(chan_run), 0, "R8 chan_run");
    chk(64'(irq), 0, "R8 irq");
    expect_rd(2, 32'h4, "R8 status");
    // R11 error clear
    wr(2, 32'h4);
    expect_rd(2, 32'h0, "R11 error cleared");
    // R9 completion with interrupt
    wr(1, 32'h1);
    pulse_ack();
    pulse_end();
    chk(64'(irq), 1, "R9 irq");
    chk(64'(chan_run), 0, "R9 chan_run");
    expect_rd(2, 32'h2, "R9 status done");
    // R10 W1C
    wr(2, 32'h0);
    chk(64'(irq), 1, "R10 write 0 keeps irq");
    wr(2, 32'h2);
    chk(64'(irq), 0, "R10 irq cleared");
    expect_rd(2, 32'h0, "R10 done cleared");
    // R12 restart with new address, interrupt disabled (R9)
    wr(3, 32'h0000_0040);
    wr(4, 32'h0000_0001);
    wr(0, 32'h1);
    wr(1, 32'h1);
    chk(64'(fetch_req), 1, "R12 restart");
    chk(64'(fetch_addr), 64'h0001_0000_0040, "R12 new addr");
    pulse_ack();
    pulse_end();
    chk(64'(irq), 0, "R9 irq disabled");
    expect_rd(2, 32'h2, "R9 done without irq");
    // R8 stop during fetch, done untouched
    wr(1, 32'h1);
    chk(64'(fetch_req), 1, "R8 fetching");
    wr(1, 32'h8);
    chk(64'(fetch_req), 0, "R8 stop in fetch");
    expect_rd(2, 32'h2, "R8 done kept");
    @(negedge clk);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule